// File: doc/BRIEF.md
# Protected Low-Side Switch Control Logic

This block is the digital control and fault core of a self-protecting low-side power switch. It takes a logic command for the switch, a level saying whether the protection supply is valid, and three synchronous detector booleans: overtemperature, short circuit and open load. It drives a gate-enable for the power stage and a fault flag that behaves like an open-drain pin: 0 means pulled low (healthy) and 1 means released (fault or warning).

A short circuit or an overtemperature seen while the protection supply is valid sets a fault latch. The latch turns the switch off and holds it off whatever the command does. Toggling the command never clears the latch. The only way to clear it is to remove the protection supply for a minimum number of consecutive sampled cycles. That count is derived from a sample-rate parameter and a minimum reset time in microseconds (150 µs by default). When the protection supply is absent, all protection is inactive: the switch simply follows the command and the flag stays released. The flag also reports an open load, but only while the switch is commanded off.

All five inputs are registered once before use, and both outputs are registered. An input change therefore shows at the outputs on the second rising clock edge after it is presented.

Top module: `lss_guard`

## Requirements
- R1: While reset is asserted, and until new inputs have propagated after release, gate_en is 0 and fault_flag is 1; the fault latch powers up cleared.
- R2: With prot_ok = 1, a short_det = 1 or ovt_det = 1 sample sets the fault latch; while it is set and prot_ok = 1, gate_en = 0 and fault_flag = 1, even after the detectors return to 0 and for any cmd_in value.
- R3: The latch clears only after prot_ok has been sampled 0 on RESET_CYCLES = CLK_HZ*RESET_US/1e6 consecutive cycles (150 with the defaults); RESET_CYCLES-1 low cycles do not clear it, a single high sample restarts the count, and cmd_in never clears it.
- R4: Normal on-state (prot_ok = 1, cmd_in = 1, no fault): gate_en = 1 and fault_flag = 0.
- R5: Normal off-state (prot_ok = 1, cmd_in = 0, no fault, no open load): gate_en = 0 and fault_flag = 0.
- R6: With prot_ok = 1 and no fault, open_det = 1 makes fault_flag = 1 only while cmd_in = 0; with cmd_in = 1 and open load, gate_en = 1 and fault_flag = 0.
- R7: With prot_ok = 1, ovt_det = 1 gives gate_en = 0 and fault_flag = 1 for either value of cmd_in.
- R8: With prot_ok = 0, fault_flag = 1 and gate_en equals cmd_in; short_det and ovt_det are ignored and do not set the latch.
- R9: Outputs reflect inputs presented before clock edge k at edge k+1; they are unchanged after edge k alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prot_ok | input | 1 | Protection supply valid level |
| cmd_in | input | 1 | Switch command, 1 = on |
| ovt_det | input | 1 | Overtemperature detect |
| short_det | input | 1 | Short-circuit detect |
| open_det | input | 1 | Open-load detect |
| gate_en | output | 1 | Power stage gate enable, registered |
| fault_flag | output | 1 | Fault flag, 1 = released, 0 = pulled low, registered |

## Verification
On every cycle the assertions check the following. A fault under a valid supply sets the latch. A set latch holds while the supply is valid and forces the outputs to off with the flag released. The latch falls only on the last cycle of a complete supply-low count. A missing supply gives a released flag, with the gate copying the command. The open-load flag follows the command in the healthy state. Only the directed scenarios can show the exact count boundary (RESET_CYCLES versus one fewer), the restart after a brief supply return, the two-edge latency, and the recovery to normal switching after a successful power cycle.

// File: rtl/lss_guard_pkg.sv
package lss_guard_pkg;

  typedef struct packed {
    logic supply;
    logic cmd;
    logic ovt;
    logic shrt;
    logic open;
  } lss_in_t;

  // Cycles of supply-low needed to clear the latch, never fewer than 2.
  function automatic int unsigned cycles_for(input int unsigned hz, input int unsigned us);
    longint unsigned c;
    c = (longint'(hz) * longint'(us)) / 64'd1_000_000;
    if (c < 2) c = 2;
    return int'(c);
  endfunction

endpackage

// File: rtl/lss_rst_sync.sv
module lss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/lss_sampler.sv
module lss_sampler
  import lss_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_q,
  input  lss_in_t raw,
  output lss_in_t smp
);
  lss_in_t smp_d;

  always_comb begin
    smp_d = raw;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) smp <= '0;
    else        smp <= smp_d;
  end
endmodule

// File: rtl/lss_reset_timer.sv
module lss_reset_timer #(
  parameter int unsigned N  = 150,
  parameter int unsigned CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          supply,
  output logic [CW-1:0] low_cnt,
  output logic          expired
);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          cnt_en;
  logic [CW-1:0] cnt_d;

  always_comb begin
    expired = !supply && (low_cnt == LAST);
    cnt_en  = supply || (low_cnt != LAST);
    if (supply) cnt_d = '0;
    else        cnt_d = low_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      low_cnt <= '0;
    else if (cnt_en) low_cnt <= cnt_d;
  end
endmodule

// File: rtl/lss_fault_latch.sv
module lss_fault_latch (
  input  logic clk,
  input  logic rst_q,
  input  logic supply,
  input  logic ovt,
  input  logic shrt,
  input  logic clear,
  output logic latch_q
);
  logic set_c;
  logic latch_d;

  always_comb begin
    set_c = supply && (ovt || shrt);
    if (set_c)      latch_d = 1'b1;
    else if (clear) latch_d = 1'b0;
    else            latch_d = latch_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) latch_q <= 1'b0;
    else        latch_q <= latch_d;
  end
endmodule

// File: rtl/lss_guard.sv
module lss_guard
  import lss_guard_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 1_000_000,
  parameter int unsigned RESET_US = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prot_ok,
  input  logic cmd_in,
  input  logic ovt_det,
  input  logic short_det,
  input  logic open_det,
  output logic gate_en,
  output logic fault_flag
);
  localparam int unsigned RESET_CYCLES = cycles_for(CLK_HZ, RESET_US);
  localparam int unsigned CW           = $clog2(RESET_CYCLES);

  logic          rst_q;
  lss_in_t       raw;
  lss_in_t       smp;
  logic          s_supply, s_cmd, s_ovt, s_shrt, s_open;
  logic [CW-1:0] low_cnt;
  logic          expired;
  logic          latch_q;
  logic          gate_d, flag_d;

  lss_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  always_comb begin
    raw.supply = prot_ok;
    raw.cmd    = cmd_in;
    raw.ovt    = ovt_det;
    raw.shrt   = short_det;
    raw.open   = open_det;
  end

  lss_sampler u_smp (.clk(clk), .rst_q(rst_q), .raw(raw), .smp(smp));

  assign s_supply = smp.supply;
  assign s_cmd    = smp.cmd;
  assign s_ovt    = smp.ovt;
  assign s_shrt   = smp.shrt;
  assign s_open   = smp.open;

  lss_reset_timer #(.N(RESET_CYCLES), .CW(CW)) u_timer (
    .clk(clk), .rst_q(rst_q), .supply(s_supply),
    .low_cnt(low_cnt), .expired(expired)
  );

  lss_fault_latch u_latch (
    .clk(clk), .rst_q(rst_q), .supply(s_supply), .ovt(s_ovt),
    .shrt(s_shrt), .clear(expired), .latch_q(latch_q)
  );

  // Output decode: supply loss first, then fault, then normal/open load.
  always_comb begin
    if (!s_supply) begin
      gate_d = s_cmd;
      flag_d = 1'b1;
    end else if (latch_q || s_ovt || s_shrt) begin
      gate_d = 1'b0;
      flag_d = 1'b1;
    end else begin
      gate_d = s_cmd;
      flag_d = s_open && !s_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      gate_en    <= 1'b0;
      fault_flag <= 1'b1;
    end else begin
      gate_en    <= gate_d;
      fault_flag <= flag_d;
    end
  end
endmodule

// File: rtl/lss_guard_chk.sv
module lss_guard_chk #(
  parameter int unsigned N  = 150,
  parameter int unsigned CW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_q,
  input logic          s_supply,
  input logic          s_cmd,
  input logic          s_ovt,
  input logic          s_shrt,
  input logic          s_open,
  input logic          latch_q,
  input logic [CW-1:0] low_cnt,
  input logic          gate_en,
  input logic          fault_flag
);
  p_fault_sets_latch_r2: assert property (@(posedge clk) disable iff (!rst_q)
    s_supply && (s_ovt || s_shrt) |=> latch_q);

  p_latch_forces_off_r2: assert property (@(posedge clk) disable iff (!rst_q)
    latch_q && s_supply |=> !gate_en && fault_flag);

  p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_q)
    latch_q && s_supply |=> latch_q);

  p_clear_after_count_r3: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(latch_q) |-> $past(!s_supply) && ($past(low_cnt) == CW'(N - 1)));

  p_supply_low_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !s_supply |=> fault_flag && (gate_en == $past(s_cmd)));

  p_open_load_r6: assert property (@(posedge clk) disable iff (!rst_q)
    s_supply && !latch_q && !s_ovt && !s_shrt |=>
      (fault_flag == $past(s_open && !s_cmd)) && (gate_en == $past(s_cmd)));

  p_ovt_off_r7: assert property (@(posedge clk) disable iff (!rst_q)
    s_supply && s_ovt |=> !gate_en && fault_flag);
endmodule

bind lss_guard lss_guard_chk #(.N(RESET_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .rst_q(rst_q), .s_supply(s_supply), .s_cmd(s_cmd),
  .s_ovt(s_ovt), .s_shrt(s_shrt), .s_open(s_open), .latch_q(latch_q),
  .low_cnt(low_cnt), .gate_en(gate_en), .fault_flag(fault_flag)
);

// File: tb/lss_guard_test.sv
module lss_guard_test;
  localparam int NCYC = 150; // 1 MHz * 150 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prot_ok = 1'b0, cmd_in = 1'b0, ovt_det = 1'b0, short_det = 1'b0, open_det = 1'b0;
  logic gate_en, fault_flag;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lss_guard uut (
    .clk(clk), .rst_n(rst_n), .prot_ok(prot_ok), .cmd_in(cmd_in),
    .ovt_det(ovt_det), .short_det(short_det), .open_det(open_det),
    .gate_en(gate_en), .fault_flag(fault_flag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic eg, input logic ef);
    checks++;
    if (gate_en !== eg || fault_flag !== ef) begin
      errors++;
      $display("FAIL %s: gate_en/fault_flag actual=%b/%b expected=%b/%b",
               req, gate_en, fault_flag, eg, ef);
    end
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 during reset", 1'b0, 1'b1);
    prot_ok = 1'b1;
    rst_n = 1'b1;
    step(3);
    chk("R1 after release, before propagation", 1'b0, 1'b1);
    step(3);
    chk("R5 off-state after reset", 1'b0, 1'b0);
  endtask

  task automatic t_normal();
    cmd_in = 1'b1;
    step(1);
    chk("R9 unchanged after one edge", 1'b0, 1'b0);
    step(1);
    chk("R9/R4 on-state after two edges", 1'b1, 1'b0);
    cmd_in = 1'b0;
    step(2);
    chk("R5 off-state", 1'b0, 1'b0);
  endtask

  task automatic t_open();
    open_det = 1'b1;
    step(2);
    chk("R6 open load while off", 1'b0, 1'b1);
    cmd_in = 1'b1;
    step(2);
    chk("R6 open load while on", 1'b1, 1'b0);
    open_det = 1'b0;
    cmd_in = 1'b0;
    step(2);
    chk("R5 open load removed", 1'b0, 1'b0);
  endtask

  task automatic power_cycle(input int low_cycles);
    prot_ok = 1'b0;
    step(low_cycles);
    prot_ok = 1'b1;
    step(3);
  endtask

  task automatic t_short_latch();
    cmd_in = 1'b1;
    step(2);
    short_det = 1'b1;
    step(2);
    chk("R2 short forces off", 1'b0, 1'b1);
    short_det = 1'b0;
    step(3);
    chk("R2 latched after short gone", 1'b0, 1'b1);
    cmd_in = 1'b0;
    step(3);
    cmd_in = 1'b1;
    step(3);
    chk("R3 command toggle does not clear", 1'b0, 1'b1);
    prot_ok = 1'b0;
    step(3);
    chk("R8 supply low follows command", 1'b1, 1'b1);
    prot_ok = 1'b1;
    step(3);
    chk("R3 short supply drop keeps latch", 1'b0, 1'b1);
    power_cycle(NCYC - 1);
    chk("R3 one cycle short of count keeps latch", 1'b0, 1'b1);
    prot_ok = 1'b0;
    step(100);
    prot_ok = 1'b1;
    step(1);
    prot_ok = 1'b0;
    step(100);
    prot_ok = 1'b1;
    step(3);
    chk("R3 interrupted count restarts", 1'b0, 1'b1);
    power_cycle(NCYC);
    chk("R3 full count clears latch", 1'b1, 1'b0);
  endtask

  task automatic t_ovt();
    cmd_in = 1'b0;
    ovt_det = 1'b1;
    step(2);
    chk("R7 overtemp with command low", 1'b0, 1'b1);
    cmd_in = 1'b1;
    step(2);
    chk("R7 overtemp with command high", 1'b0, 1'b1);
    ovt_det = 1'b0;
    step(3);
    chk("R2 overtemp latched", 1'b0, 1'b1);
    power_cycle(NCYC + 4);
    chk("R3 cleared after long drop", 1'b1, 1'b0);
  endtask

  task automatic t_supply_low_ignores();
    cmd_in = 1'b1;
    prot_ok = 1'b0;
    step(3);
    short_det = 1'b1;
    ovt_det = 1'b1;
    step(3);
    chk("R8 detects ignored, gate follows", 1'b1, 1'b1);
    cmd_in = 1'b0;
    step(2);
    chk("R8 gate follows command low", 1'b0, 1'b1);
    short_det = 1'b0;
    ovt_det = 1'b0;
    cmd_in = 1'b1;
    step(2);
    prot_ok = 1'b1;
    step(3);
    chk("R8 no latch set during supply low", 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_open();
    t_short_latch();
    t_ovt();
    t_supply_low_ignores();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule